// File: doc/BRIEF.md
# SPI Master Byte Transfer Engine

The engine is the shifting core of an SPI master. Software, through a separate register wrapper, writes bytes into a 64-entry transmit FIFO. It programs a total burst length and a smaller or equal transmit length, then sets the exchange bit. The engine then clocks exactly the burst length in 8-bit frames on `sclk_o`/`mosi_o`/`miso_i`. Bytes past the transmit length go out as zeros. Every received byte lands in a 64-entry receive FIFO, unless the discard option is set. Clock polarity, clock phase and bit order can each be chosen.

A separate divider supplies a one-cycle strobe every half SCLK period, and every SCLK edge and the closing chip-select gap follow that strobe. One of four chip-select lines is picked. It is either asserted by the engine for the whole burst, or held at a level that software sets. A polarity control sets the resting level of every unselected line. If the transmit FIFO runs dry while transmit bytes are still owed, SCLK stops at its idle level until data arrives. When the last frame is stored, a one-cycle completion pulse fires and the busy readback falls.

Top module: `spi_xfer_engine`

## Requirements
- R1: Each FIFO holds 64 bytes and reports a 7-bit occupancy. A full FIFO reports 64, and a push into a full FIFO leaves the count unchanged.
- R2: A start request that is accepted makes `xch_o` read 1 from the next clock edge. `xch_o` stays 1 until the burst ends and reads 0 in the same cycle that `done_o` is high.
- R3: A burst carries exactly `burst_len_i` frames. The first `min(tx_len_i, burst_len_i)` frames are popped from the transmit FIFO, and the rest are 0x00. Unused FIFO bytes stay in the FIFO.
- R4: With `discard_rx_i` = 0 each received frame is pushed into the receive FIFO in order. With it = 1 the receive FIFO is left untouched.
- R5: `sclk_o` rests at `cpol_i` when idle. With `cpha_i` = 0, data is sampled on the first edge of each bit and changed on the second. With `cpha_i` = 1 the roles swap.
- R6: With `lsb_first_i` = 1, bit 0 of each frame is sent and received first. Otherwise bit 7 goes first.
- R7: While transmit frames remain and the transmit FIFO is empty, SCLK makes no edge and `xch_o` stays 1. The burst resumes once a byte is written.
- R8: A one-cycle pulse on `tx_flush_i` or `rx_flush_i` empties the corresponding FIFO.
- R9: `cs_sel_i` picks one line of `cs_o`. Unselected lines rest at `cs_active_low_i`. In manual mode the selected line equals `cs_level_i`. In automatic mode it is active (low when `cs_active_low_i` = 1) exactly while `xch_o` is 1.
- R10: A start request is ignored unless both `enable_i` and `master_i` are 1.
- R11: `done_o` is a single-cycle pulse per burst. It comes one half-tick after the last SCLK edge, and the final received frame is already counted in `rx_count_o`. A zero burst length yields the pulse with no SCLK edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| enable_i | input | 1 | Global enable |
| master_i | input | 1 | Master mode select |
| cpol_i | input | 1 | SCLK idle level |
| cpha_i | input | 1 | Sample on second edge when 1 |
| lsb_first_i | input | 1 | Bit order, LSB first when 1 |
| discard_rx_i | input | 1 | Do not store received frames |
| cs_sel_i | input | 2 | Chip-select line index |
| cs_manual_i | input | 1 | Manual chip-select mode |
| cs_level_i | input | 1 | Selected line level in manual mode |
| cs_active_low_i | input | 1 | Chip-select polarity and idle level |
| burst_len_i | input | 24 | Total frames per burst |
| tx_len_i | input | 24 | Frames taken from the transmit FIFO |
| xch_set_i | input | 1 | Start request pulse |
| xch_o | output | 1 | Burst in progress |
| done_o | output | 1 | Burst completion pulse |
| tx_flush_i | input | 1 | Empty transmit FIFO |
| rx_flush_i | input | 1 | Empty receive FIFO |
| tx_wr_i | input | 1 | Push into transmit FIFO |
| tx_wdata_i | input | 8 | Byte to push |
| rx_rd_i | input | 1 | Pop from receive FIFO |
| rx_rdata_o | output | 8 | Head of receive FIFO |
| tx_count_o | output | 7 | Transmit FIFO occupancy |
| rx_count_o | output | 7 | Receive FIFO occupancy |
| half_tick_i | input | 1 | Half SCLK period strobe |
| sclk_o | output | 1 | Serial clock |
| mosi_o | output | 1 | Serial data out |
| miso_i | input | 1 | Serial data in |
| cs_o | output | 4 | Chip-select lines |

## Verification
FIFO occupancy and `xch_o` change one clock edge after the push, pop, flush or start that causes them. The bench drives these inputs at a falling edge and reads the result at the next falling edge. Each frame takes sixteen half-tick strobes, and the slave model sees an SCLK edge in the cycle after the strobe clock edge. The model samples 1 ns after that rising edge, before MOSI can move on the opposite edge, and it drives MISO well ahead of the next sampling strobe. `done_o` and the fall of `xch_o` share one edge, and the bench checks both at the same falling edge. It then checks that the pulse is gone one cycle later.

// File: rtl/spi_xfer_pkg.sv
package spi_xfer_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_LOAD  = 2'd1,
    ST_SHIFT = 2'd2,
    ST_TAIL  = 2'd3
  } xfer_state_e;

  localparam int unsigned FRAME_W = 8;
endpackage

// File: rtl/spi_byte_fifo.sv
module spi_byte_fifo #(
  parameter int unsigned DEPTH = 64,
  parameter int unsigned WIDTH = 8,
  localparam int unsigned AW = $clog2(DEPTH),
  localparam int unsigned CW = AW + 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             flush_i,
  input  logic             push_i,
  input  logic [WIDTH-1:0] wdata_i,
  input  logic             pop_i,
  output logic [WIDTH-1:0] rdata_o,
  output logic [CW-1:0]    count_o
);
  logic [WIDTH-1:0] mem_q [DEPTH];
  logic [AW-1:0]    wp_q, rp_q;
  logic [CW-1:0]    cnt_q;
  logic             full, empty, do_push, do_pop;

  assign full    = (cnt_q == CW'(DEPTH));
  assign empty   = (cnt_q == '0);
  assign do_push = push_i && !full && !flush_i;
  assign do_pop  = pop_i && !empty && !flush_i;

  always_ff @(posedge clk_i) begin
    if (do_push) mem_q[wp_q] <= wdata_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wp_q  <= '0;
      rp_q  <= '0;
      cnt_q <= '0;
    end else if (flush_i) begin
      wp_q  <= '0;
      rp_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (do_push) wp_q <= wp_q + 1'b1;
      if (do_pop)  rp_q <= rp_q + 1'b1;
      case ({do_push, do_pop})
        2'b10:   cnt_q <= cnt_q + 1'b1;
        2'b01:   cnt_q <= cnt_q - 1'b1;
        default: cnt_q <= cnt_q;
      endcase
    end
  end

  assign rdata_o = mem_q[rp_q];
  assign count_o = cnt_q;

  AST_NO_OVERFLOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= CW'(DEPTH)); // R1
  AST_FULL_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (full && !pop_i && !flush_i) |=> (cnt_q == CW'(DEPTH))); // R1
endmodule

// File: rtl/spi_shift_core.sv
module spi_shift_core
  import spi_xfer_pkg::*;
#(
  parameter int unsigned CNT_W = 24
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               start_i,
  input  logic               cpol_i,
  input  logic               cpha_i,
  input  logic               lsb_first_i,
  input  logic               discard_rx_i,
  input  logic [CNT_W-1:0]   burst_len_i,
  input  logic [CNT_W-1:0]   tx_len_i,
  input  logic               half_tick_i,
  input  logic               tx_empty_i,
  input  logic [FRAME_W-1:0] tx_data_i,
  input  logic               miso_i,
  output logic               tx_pop_o,
  output logic               rx_push_o,
  output logic [FRAME_W-1:0] rx_data_o,
  output logic               sclk_o,
  output logic               mosi_o,
  output logic               busy_o,
  output logic               done_o
);
  xfer_state_e        state_q;
  logic [CNT_W-1:0]   rem_q, txl_q;
  logic [3:0]         half_q;
  logic               sclk_q, done_q;
  logic [FRAME_W-1:0] tx_sh_q, rx_sh_q, rx_next;
  logic               need_tx, sample_edge, shift_edge, fire, last_half;

  assign need_tx     = (txl_q != '0);
  // even half index = leading edge
  assign sample_edge = cpha_i ? half_q[0] : ~half_q[0];
  assign shift_edge  = ~sample_edge && !(cpha_i && half_q == 4'd0);
  assign fire        = (state_q == ST_SHIFT) && half_tick_i;
  assign last_half   = (half_q == 4'hF);
  assign rx_next     = lsb_first_i ? {miso_i, rx_sh_q[FRAME_W-1:1]}
                                   : {rx_sh_q[FRAME_W-2:0], miso_i};

  assign tx_pop_o  = (state_q == ST_LOAD) && need_tx && !tx_empty_i;
  assign rx_push_o = fire && last_half && !discard_rx_i;
  assign rx_data_o = sample_edge ? rx_next : rx_sh_q;
  assign mosi_o    = lsb_first_i ? tx_sh_q[0] : tx_sh_q[FRAME_W-1];
  assign sclk_o    = sclk_q;
  assign busy_o    = (state_q != ST_IDLE);
  assign done_o    = done_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      rem_q   <= '0;
      txl_q   <= '0;
      half_q  <= '0;
      sclk_q  <= 1'b0;
      tx_sh_q <= '0;
      rx_sh_q <= '0;
      done_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      case (state_q)
        ST_IDLE: begin
          sclk_q <= cpol_i;
          if (start_i) begin
            rem_q   <= burst_len_i;
            txl_q   <= tx_len_i;
            state_q <= (burst_len_i == '0) ? ST_TAIL : ST_LOAD;
          end
        end
        ST_LOAD: begin
          if (need_tx) begin
            if (!tx_empty_i) begin
              tx_sh_q <= tx_data_i;
              txl_q   <= txl_q - 1'b1;
              half_q  <= '0;
              state_q <= ST_SHIFT;
            end
          end else begin
            tx_sh_q <= '0;
            half_q  <= '0;
            state_q <= ST_SHIFT;
          end
        end
        ST_SHIFT: begin
          if (half_tick_i) begin
            sclk_q <= ~sclk_q;
            half_q <= half_q + 1'b1;
            if (sample_edge) rx_sh_q <= rx_next;
            if (shift_edge)
              tx_sh_q <= lsb_first_i ? (tx_sh_q >> 1) : (tx_sh_q << 1);
            if (last_half) begin
              rem_q   <= rem_q - 1'b1;
              state_q <= (rem_q == CNT_W'(1)) ? ST_TAIL : ST_LOAD;
            end
          end
        end
        ST_TAIL: begin
          if (half_tick_i) begin
            state_q <= ST_IDLE;
            done_q  <= 1'b1;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  AST_SCLK_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_IDLE && $past(state_q == ST_IDLE) && $stable(cpol_i)) |-> (sclk_q == cpol_i)); // R5
  AST_REM_NO_UP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q != ST_IDLE && $past(state_q != ST_IDLE)) |-> (rem_q <= $past(rem_q))); // R3
  AST_STALL_NO_EDGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_LOAD) |=> $stable(sclk_q)); // R7
  AST_DONE_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_q |-> (state_q == ST_IDLE)); // R2
endmodule

// File: rtl/spi_cs_ctrl.sv
module spi_cs_ctrl #(
  parameter int unsigned N_CS = 4,
  localparam int unsigned SEL_W = $clog2(N_CS)
) (
  input  logic [SEL_W-1:0] sel_i,
  input  logic             manual_i,
  input  logic             level_i,
  input  logic             active_low_i,
  input  logic             busy_i,
  output logic [N_CS-1:0]  cs_o
);
  for (genvar g = 0; g < N_CS; g++) begin : g_line
    always_comb begin
      if (sel_i == SEL_W'(g))
        cs_o[g] = manual_i ? level_i : (busy_i ^ active_low_i);
      else
        cs_o[g] = active_low_i;
    end
  end
endmodule

// File: rtl/spi_xfer_engine.sv
module spi_xfer_engine
  import spi_xfer_pkg::*;
#(
  parameter int unsigned FIFO_DEPTH = 64,
  parameter int unsigned CNT_W      = 24,
  parameter int unsigned N_CS       = 4,
  localparam int unsigned CW        = $clog2(FIFO_DEPTH) + 1,
  localparam int unsigned SEL_W     = $clog2(N_CS)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               enable_i,
  input  logic               master_i,
  input  logic               cpol_i,
  input  logic               cpha_i,
  input  logic               lsb_first_i,
  input  logic               discard_rx_i,
  input  logic [SEL_W-1:0]   cs_sel_i,
  input  logic               cs_manual_i,
  input  logic               cs_level_i,
  input  logic               cs_active_low_i,
  input  logic [CNT_W-1:0]   burst_len_i,
  input  logic [CNT_W-1:0]   tx_len_i,
  input  logic               xch_set_i,
  output logic               xch_o,
  output logic               done_o,
  input  logic               tx_flush_i,
  input  logic               rx_flush_i,
  input  logic               tx_wr_i,
  input  logic [FRAME_W-1:0] tx_wdata_i,
  input  logic               rx_rd_i,
  output logic [FRAME_W-1:0] rx_rdata_o,
  output logic [CW-1:0]      tx_count_o,
  output logic [CW-1:0]      rx_count_o,
  input  logic               half_tick_i,
  output logic               sclk_o,
  output logic               mosi_o,
  input  logic               miso_i,
  output logic [N_CS-1:0]    cs_o
);
  logic               busy, start, tx_pop, rx_push;
  logic [FRAME_W-1:0] tx_head, rx_wdata;

  assign start = xch_set_i && enable_i && master_i && !busy;
  assign xch_o = busy;

  spi_byte_fifo #(.DEPTH(FIFO_DEPTH), .WIDTH(FRAME_W)) u_tx_fifo (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .flush_i (tx_flush_i),
    .push_i  (tx_wr_i),
    .wdata_i (tx_wdata_i),
    .pop_i   (tx_pop),
    .rdata_o (tx_head),
    .count_o (tx_count_o)
  );

  spi_byte_fifo #(.DEPTH(FIFO_DEPTH), .WIDTH(FRAME_W)) u_rx_fifo (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .flush_i (rx_flush_i),
    .push_i  (rx_push),
    .wdata_i (rx_wdata),
    .pop_i   (rx_rd_i),
    .rdata_o (rx_rdata_o),
    .count_o (rx_count_o)
  );

  spi_shift_core #(.CNT_W(CNT_W)) u_core (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .start_i      (start),
    .cpol_i       (cpol_i),
    .cpha_i       (cpha_i),
    .lsb_first_i  (lsb_first_i),
    .discard_rx_i (discard_rx_i),
    .burst_len_i  (burst_len_i),
    .tx_len_i     (tx_len_i),
    .half_tick_i  (half_tick_i),
    .tx_empty_i   (tx_count_o == '0),
    .tx_data_i    (tx_head),
    .miso_i       (miso_i),
    .tx_pop_o     (tx_pop),
    .rx_push_o    (rx_push),
    .rx_data_o    (rx_wdata),
    .sclk_o       (sclk_o),
    .mosi_o       (mosi_o),
    .busy_o       (busy),
    .done_o       (done_o)
  );

  spi_cs_ctrl #(.N_CS(N_CS)) u_cs (
    .sel_i        (cs_sel_i),
    .manual_i     (cs_manual_i),
    .level_i      (cs_level_i),
    .active_low_i (cs_active_low_i),
    .busy_i       (busy),
    .cs_o         (cs_o)
  );

  AST_CS_ONE_ACTIVE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones(cs_o ^ {N_CS{cs_active_low_i}}) <= 1); // R9
  AST_DISCARD_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (discard_rx_i && !rx_rd_i && !rx_flush_i) |=> (rx_count_o == $past(rx_count_o))); // R4
  AST_START_GATED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy && !(enable_i && master_i)) |=> !busy); // R10
endmodule

// File: tb/spi_xfer_engine_tb_top.sv
`timescale 1ns/1ps
module spi_xfer_engine_tb_top;
  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rst_n, en, mst, cpol, cpha, lsb, disc, cs_man, cs_lvl, cs_al;
  logic [1:0]  cs_sel;
  logic [23:0] blen, tlen;
  logic xch_set, xch, done, tx_fl, rx_fl, tx_wr, rx_rd, tick, sclk, mosi, miso;
  logic [7:0] tx_wd, rx_rdata;
  logic [6:0] tx_cnt, rx_cnt;
  logic [3:0] cs;

  spi_xfer_engine dut_i (
    .clk_i(clk), .rst_ni(rst_n), .enable_i(en), .master_i(mst),
    .cpol_i(cpol), .cpha_i(cpha), .lsb_first_i(lsb), .discard_rx_i(disc),
    .cs_sel_i(cs_sel), .cs_manual_i(cs_man), .cs_level_i(cs_lvl), .cs_active_low_i(cs_al),
    .burst_len_i(blen), .tx_len_i(tlen), .xch_set_i(xch_set), .xch_o(xch), .done_o(done),
    .tx_flush_i(tx_fl), .rx_flush_i(rx_fl), .tx_wr_i(tx_wr), .tx_wdata_i(tx_wd),
    .rx_rd_i(rx_rd), .rx_rdata_o(rx_rdata), .tx_count_o(tx_cnt), .rx_count_o(rx_cnt),
    .half_tick_i(tick), .sclk_o(sclk), .mosi_o(mosi), .miso_i(miso), .cs_o(cs)
  );

  int n_chk = 0, n_err = 0;
  byte unsigned mosi_q[$], slv_q[$], rx_q[$];

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  endtask

  function automatic byte unsigned pat(input int s, input int i);
    return 8'(s * 29 + i * 53 + 7);
  endfunction

  function automatic logic [3:0] busy_cs();
    logic [3:0] sel = 4'b0001 << cs_sel;
    return cs_al ? ~sel : sel;
  endfunction

  initial begin
    tick = 1'b0;
    forever begin
      @(negedge clk);
      tick = ~tick;
    end
  end

  // slave model and monitor side of the scoreboard
  initial begin : mon
    logic prev;
    int sb;
    byte unsigned acc, e;
    prev = 1'b0; sb = 0; acc = 8'h00; miso = 1'b0;
    forever begin
      @(posedge clk);
      #1;
      if (rst_n && xch && sclk != prev) begin
        if (cpha ? (sclk == cpol) : (sclk != cpol)) begin
          acc = lsb ? {mosi, acc[7:1]} : {acc[6:0], mosi};
          sb++;
          if (sb == 8) begin
            sb = 0;
            if (mosi_q.size() == 0) chk(1'b0, "R3 extra frame", acc, 0);
            else begin
              e = mosi_q.pop_front();
              chk(acc == e, "R5 R6 mosi frame", acc, e);
            end
            chk(cs == busy_cs(), "R9 auto cs", cs, busy_cs());
            if (slv_q.size() > 0) void'(slv_q.pop_front());
          end
        end
      end
      prev = sclk;
      if (slv_q.size() > 0) miso = lsb ? slv_q[0][sb] : slv_q[0][7-sb];
      else miso = 1'b0;
    end
  end

  task automatic push_tx(input byte unsigned d);
    @(negedge clk); tx_wr = 1'b1; tx_wd = d;
    @(negedge clk); tx_wr = 1'b0;
  endtask

  // driver side: fills FIFO and queues expected frames
  task automatic prep(input int burst, input int txc, input int seed, input int npush, input bit keep);
    for (int i = 0; i < npush; i++) push_tx(pat(seed, i));
    for (int i = 0; i < burst; i++) begin
      mosi_q.push_back(i < txc ? pat(seed, i) : 8'h00);
      slv_q.push_back(pat(seed + 100, i));
      if (keep) rx_q.push_back(pat(seed + 100, i));
    end
    blen = 24'(burst); tlen = 24'(txc);
  endtask

  task automatic kick();
    @(negedge clk); xch_set = 1'b1;
    @(negedge clk); xch_set = 1'b0;
    chk(xch == 1'b1, "R2 busy after start", xch, 1);
  endtask

  task automatic wait_done();
    int c = 0;
    while (!done && c < 20000) begin @(negedge clk); c++; end
    chk(done == 1'b1, "R11 done seen", done, 1);
    chk(xch == 1'b0, "R2 busy clears with done", xch, 0);
    chk(mosi_q.size() == 0, "R3 frame count", mosi_q.size(), 0);
    @(negedge clk);
    chk(done == 1'b0, "R11 single pulse", done, 0);
  endtask

  task automatic drain_rx();
    byte unsigned e;
    chk(rx_cnt == 7'(rx_q.size()), "R11 rx stored before done", rx_cnt, rx_q.size());
    while (rx_q.size() > 0) begin
      e = rx_q.pop_front();
      chk(rx_rdata == e, "R4 rx frame", rx_rdata, e);
      rx_rd = 1'b1; @(negedge clk); rx_rd = 1'b0;
    end
    chk(rx_cnt == 7'd0, "R4 rx drained", rx_cnt, 0);
  endtask

  task automatic pulse_flush(input bit t, input bit r);
    @(negedge clk); tx_fl = t; rx_fl = r;
    @(negedge clk); tx_fl = 1'b0; rx_fl = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_err++;
    $display("FAIL watchdog: actual hung expected finished");
    summary();
  end

  initial begin
    rst_n = 1'b0; en = 1'b1; mst = 1'b1; cpol = 1'b0; cpha = 1'b0; lsb = 1'b0; disc = 1'b0;
    cs_man = 1'b0; cs_lvl = 1'b0; cs_al = 1'b1; cs_sel = 2'd0; blen = '0; tlen = '0;
    xch_set = 1'b0; tx_fl = 1'b0; rx_fl = 1'b0; tx_wr = 1'b0; tx_wd = '0; rx_rd = 1'b0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(xch == 1'b0, "R2 reset idle", xch, 0);
    chk(tx_cnt == 7'd0 && rx_cnt == 7'd0, "R1 reset counts", {tx_cnt, rx_cnt}, 0);
    chk(cs == 4'hF, "R9 reset cs idle", cs, 4'hF);
    chk(sclk == 1'b0, "R5 reset sclk", sclk, 0);

    // mode 0, msb first
    cs_sel = 2'd1;
    prep(4, 4, 1, 4, 1); kick(); wait_done(); drain_rx();

    // mode 3, lsb first
    cpol = 1'b1; cpha = 1'b1; lsb = 1'b1; cs_sel = 2'd2;
    repeat (3) @(negedge clk);
    chk(sclk == 1'b1, "R5 idle level follows cpol", sclk, 1);
    prep(3, 3, 2, 3, 1); kick(); wait_done(); drain_rx();

    // tx count shorter than burst: zero fill
    cpol = 1'b0; cpha = 1'b1; lsb = 1'b0;
    prep(5, 2, 3, 3, 1); kick(); wait_done(); drain_rx();
    chk(tx_cnt == 7'd1, "R3 unused tx byte kept", tx_cnt, 1);
    pulse_flush(1'b1, 1'b0);
    chk(tx_cnt == 7'd0, "R8 tx flush", tx_cnt, 0);

    // discard receive
    cpol = 1'b1; cpha = 1'b0; disc = 1'b1;
    prep(3, 3, 4, 3, 0); kick(); wait_done();
    chk(rx_cnt == 7'd0, "R4 discard keeps rx empty", rx_cnt, 0);
    disc = 1'b0;

    // stall on empty transmit FIFO
    cpol = 1'b0; cpha = 1'b0;
    prep(2, 2, 5, 1, 1); kick();
    repeat (80) @(negedge clk);
    chk(xch == 1'b1, "R7 busy while stalled", xch, 1);
    chk(sclk == cpol, "R7 sclk parked", sclk, cpol);
    chk(mosi_q.size() == 1, "R7 one frame sent", mosi_q.size(), 1);
    push_tx(pat(5, 1));
    wait_done(); drain_rx();

    // FIFO capacity and receive flush
    for (int i = 0; i < 65; i++) push_tx(8'(i));
    chk(tx_cnt == 7'd64, "R1 full count", tx_cnt, 64);
    pulse_flush(1'b1, 1'b0);
    prep(2, 2, 6, 2, 0); kick(); wait_done();
    chk(rx_cnt == 7'd2, "R4 rx stored", rx_cnt, 2);
    pulse_flush(1'b0, 1'b1);
    chk(rx_cnt == 7'd0, "R8 rx flush", rx_cnt, 0);

    // start gated by enable and master
    en = 1'b0; blen = 24'd1; tlen = 24'd0;
    @(negedge clk); xch_set = 1'b1; @(negedge clk); xch_set = 1'b0;
    chk(xch == 1'b0, "R10 disabled start ignored", xch, 0);
    en = 1'b1; mst = 1'b0;
    @(negedge clk); xch_set = 1'b1; @(negedge clk); xch_set = 1'b0;
    repeat (4) @(negedge clk);
    chk(xch == 1'b0 && done == 1'b0, "R10 slave mode start ignored", xch, 0);
    mst = 1'b1;

    // zero-length burst
    blen = 24'd0; tlen = 24'd0;
    kick(); wait_done();

    // manual chip select
    cs_man = 1'b1; cs_sel = 2'd3; cs_al = 1'b0; cs_lvl = 1'b0;
    #1 chk(cs == 4'b0000, "R9 manual low, idle low", cs, 4'b0000);
    cs_lvl = 1'b1;
    #1 chk(cs == 4'b1000, "R9 manual high", cs, 4'b1000);
    cs_al = 1'b1; cs_lvl = 1'b0;
    #1 chk(cs == 4'b0111, "R9 manual low, idle high", cs, 4'b0111);

    summary();
  end
endmodule